// File: doc/BRIEF.md
# Universal Shift Register with JK Entry Stage

This block is a clocked register of `WIDTH` stages that does one of two things on every rising clock edge. A single active-low control selects the operation. When the control is low, every stage captures its own bit from a parallel input word. When it is high, the contents move one stage toward the last stage.

During a move, the first stage does not take a plain serial bit. It is written through a J input (active high) and a K input (active low), so it can be set, cleared, toggled or held. If the two entry inputs are tied together, the first stage behaves as an ordinary serial data input. An active-low master reset clears every stage at once, with no clock needed. Every stage is visible on a parallel output, and a separate output gives the inverse of the last stage.

A shift toward stage 0 is not built in. The surrounding logic gets it by feeding each `q_out[n]` back to `par_in[n-1]` and holding the load control low.

Top module: `ushj_top`

## Requirements
- R1: While `rst_n` is low, `q_out` is all zeros and `q_last_n` is 1. This holds at once, without a clock edge, and whatever the other inputs are.
- R2: On a rising edge with `rst_n` high and `par_load_n` = 0, each `q_out[n]` takes `par_in[n]`.
- R3: On a rising edge with `rst_n` high and `par_load_n` = 1, each stage n ≥ 1 takes the value that stage n-1 held before the edge.
- R4: In a shift with `ser_j` = 1 and `ser_kn` = 1, stage 0 becomes 1.
- R5: In a shift with `ser_j` = 0 and `ser_kn` = 0, stage 0 becomes 0.
- R6: In a shift with `ser_j` = 1 and `ser_kn` = 0, stage 0 becomes the inverse of its previous value.
- R7: In a shift with `ser_j` = 0 and `ser_kn` = 1, stage 0 keeps its previous value.
- R8: `q_last_n` always equals the inverse of `q_out[WIDTH-1]`.
- R9: Input changes between rising edges have no effect on `q_out` until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on its rising edge |
| rst_n | input | 1 | Asynchronous master reset, active low |
| par_load_n | input | 1 | 0 = parallel load, 1 = shift toward the last stage |
| ser_j | input | 1 | J entry of stage 0, active high |
| ser_kn | input | 1 | K entry of stage 0, active low |
| par_in | input | WIDTH | Parallel data, bit n goes to stage n |
| q_out | output | WIDTH | Stage contents, bit n is stage n |
| q_last_n | output | 1 | Inverse of stage WIDTH-1 |

## Verification
The bound checker looks at every clock edge after reset. It checks the parallel capture, the one-stage move, each of the four entry actions on stage 0, the inverted last-stage output, and the cleared state while reset is held. Some behaviour can only be shown by the bench's own scenarios. Reset has to clear the register between clock edges. Inputs that change mid-cycle must leave the outputs alone. And a shift toward stage 0 has to work when it is built from external feedback through the load path.

// File: rtl/ushj_pkg.sv
package ushj_pkg;

    // Operation picked by the load control on each edge
    typedef enum logic {
        MODE_LOAD  = 1'b0,
        MODE_SHIFT = 1'b1
    } ushj_mode_e;

    // Stage-0 entry action, encoded as {j, kn}
    typedef enum logic [1:0] {
        ENTRY_CLEAR  = 2'b00,
        ENTRY_HOLD   = 2'b01,
        ENTRY_TOGGLE = 2'b10,
        ENTRY_SET    = 2'b11
    } ushj_entry_e;

endpackage

// File: rtl/ushj_mode_dec.sv
module ushj_mode_dec
    import ushj_pkg::*;
(
    input  logic       par_load_n,
    output ushj_mode_e mode
);
    always_comb begin
        mode = par_load_n ? MODE_SHIFT : MODE_LOAD;
    end
endmodule

// File: rtl/ushj_entry.sv
module ushj_entry
    import ushj_pkg::*;
(
    input  logic ser_j,
    input  logic ser_kn,
    input  logic stage0_q,
    output logic stage0_shift_d
);
    ushj_entry_e action;

    always_comb begin
        action = ushj_entry_e'({ser_j, ser_kn});
        unique case (action)
            ENTRY_CLEAR:  stage0_shift_d = 1'b0;
            ENTRY_HOLD:   stage0_shift_d = stage0_q;
            ENTRY_TOGGLE: stage0_shift_d = ~stage0_q;
            ENTRY_SET:    stage0_shift_d = 1'b1;
            default:      stage0_shift_d = stage0_q;
        endcase
    end
endmodule

// File: rtl/ushj_stage_mux.sv
module ushj_stage_mux
    import ushj_pkg::*;
(
    input  ushj_mode_e mode,
    input  logic       load_bit,
    input  logic       shift_bit,
    output logic       next_bit
);
    always_comb begin
        next_bit = (mode == MODE_LOAD) ? load_bit : shift_bit;
    end
endmodule

// File: rtl/ushj_top.sv
module ushj_top
    import ushj_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             par_load_n,
    input  logic             ser_j,
    input  logic             ser_kn,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] q_out,
    output logic             q_last_n
);
    localparam int LAST = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] stages;
    } state_t;

    state_t           state_d;
    state_t           state_q;
    ushj_mode_e       mode;
    logic             entry_bit;
    logic [WIDTH-1:0] shift_src;
    logic [WIDTH-1:0] stage_next;

    ushj_mode_dec u_mode (
        .par_load_n (par_load_n),
        .mode       (mode)
    );

    ushj_entry u_entry (
        .ser_j          (ser_j),
        .ser_kn         (ser_kn),
        .stage0_q       (state_q.stages[0]),
        .stage0_shift_d (entry_bit)
    );

    // Source each stage would take during a shift
    always_comb begin
        shift_src = {state_q.stages[LAST-1:0], entry_bit};
    end

    for (genvar n = 0; n < WIDTH; n++) begin : g_stage
        ushj_stage_mux u_mux (
            .mode      (mode),
            .load_bit  (par_in[n]),
            .shift_bit (shift_src[n]),
            .next_bit  (stage_next[n])
        );
    end

    always_comb begin
        state_d        = state_q;
        state_d.stages = stage_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign q_out    = state_q.stages;
    assign q_last_n = ~state_q.stages[LAST];

endmodule

// File: rtl/ushj_checker.sv
module ushj_checker #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             par_load_n,
    input logic             ser_j,
    input logic             ser_kn,
    input logic [WIDTH-1:0] par_in,
    input logic [WIDTH-1:0] q_out,
    input logic             q_last_n
);
    // Reset clears all stages (R1)
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |-> (q_out == '0 && q_last_n));

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !par_load_n |=> q_out == $past(par_in));

    assert_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        par_load_n |=> q_out[WIDTH-1:1] == $past(q_out[WIDTH-2:0]));

    assert_entry_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (par_load_n && ser_j && ser_kn) |=> q_out[0]);

    assert_entry_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (par_load_n && !ser_j && !ser_kn) |=> !q_out[0]);

    assert_entry_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (par_load_n && ser_j && !ser_kn) |=> q_out[0] != $past(q_out[0]));

    assert_entry_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (par_load_n && !ser_j && ser_kn) |=> q_out[0] == $past(q_out[0]));

    assert_last_inv_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q_last_n != q_out[WIDTH-1]);

endmodule

bind ushj_top ushj_checker #(.WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .par_load_n (par_load_n),
    .ser_j      (ser_j),
    .ser_kn     (ser_kn),
    .par_in     (par_in),
    .q_out      (q_out),
    .q_last_n   (q_last_n)
);

// File: tb/ushj_top_bench.sv
module ushj_top_bench;
    localparam int W = 4;
    localparam int NV = 12;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         par_load_n;
    logic         ser_j;
    logic         ser_kn;
    logic [W-1:0] par_in;
    logic [W-1:0] q_out;
    logic         q_last_n;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    ushj_top #(.WIDTH(W)) u_ushj_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .par_load_n (par_load_n),
        .ser_j      (ser_j),
        .ser_kn     (ser_kn),
        .par_in     (par_in),
        .q_out      (q_out),
        .q_last_n   (q_last_n)
    );

    // {par_load_n, j, kn, par_in, expected q_out}; starts from cleared state
    localparam logic [10:0] VECS [NV] = '{
        {1'b0, 1'b0, 1'b0, 4'hA, 4'hA},  // R2 load
        {1'b1, 1'b1, 1'b1, 4'h0, 4'h5},  // R3 R4 set
        {1'b1, 1'b0, 1'b0, 4'hF, 4'hA},  // R3 R5 clear
        {1'b1, 1'b1, 1'b0, 4'h0, 4'h5},  // R3 R6 toggle 0->1
        {1'b1, 1'b1, 1'b0, 4'h0, 4'hA},  // R3 R6 toggle 1->0
        {1'b1, 1'b0, 1'b1, 4'hF, 4'h4},  // R3 R7 hold 0
        {1'b0, 1'b1, 1'b0, 4'h7, 4'h7},  // R2 load
        {1'b1, 1'b0, 1'b1, 4'h0, 4'hF},  // R3 R7 hold 1
        {1'b1, 1'b1, 1'b1, 4'h0, 4'hF},  // R3 R4 set
        {1'b1, 1'b0, 1'b0, 4'h0, 4'hE},  // R3 R5 clear
        {1'b0, 1'b0, 1'b0, 4'h3, 4'h3},  // R2 load
        {1'b1, 1'b1, 1'b1, 4'h0, 4'h7}   // R3 serial D via tied J/K
    };

    task automatic check(input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_inv(input string tag);
        n_run++;
        if (q_last_n !== ~q_out[W-1]) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, q_last_n, ~q_out[W-1]);
        end
    endtask

    initial begin
        #1600000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] model;
        rst_n = 1'b0; par_load_n = 1'b1; ser_j = 1'b1; ser_kn = 1'b1; par_in = '1;
        #3;
        check("R1 reset state", q_out, '0);
        check("R1 reset inverted out", {3'b0, q_last_n}, 4'h1);
        @(negedge clk);
        check("R1 reset held over edge", q_out, '0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            {par_load_n, ser_j, ser_kn, par_in} = VECS[i][10:4];
            @(negedge clk);
            check($sformatf("R2/R3-R7 vector %0d", i), q_out, VECS[i][3:0]);
            check_inv($sformatf("R8 vector %0d", i));
        end
        model = 4'h7;

        // R9: mid-cycle change does nothing before the edge
        par_load_n = 1'b0; par_in = 4'h5;
        #2;
        check("R9 no change before edge", q_out, model);
        @(negedge clk);
        model = 4'h5;
        check("R9 takes effect at edge", q_out, model);

        // R1: reset in the middle of a sequence, between edges
        par_load_n = 1'b1; ser_j = 1'b1; ser_kn = 1'b1;
        #1;
        rst_n = 1'b0;
        #1;
        check("R1 async clear mid-cycle", q_out, '0);
        check_inv("R8 during reset");
        @(negedge clk);
        check("R1 clear holds against shift", q_out, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R4 first shift after reset", q_out, 4'h1);

        // R2: shift toward stage 0 via feedback through the load path
        par_load_n = 1'b0; par_in = 4'h9;
        @(negedge clk);
        model = 4'h9;
        check("R2 load before left shift", q_out, model);
        for (int s = 0; s < 3; s++) begin
            par_in = {1'b0, q_out[W-1:1]};
            @(negedge clk);
            model = {1'b0, model[W-1:1]};
            check($sformatf("R2 left shift %0d", s), q_out, model);
            check_inv("R8 left shift");
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule